// File: doc/BRIEF.md
# Interrupt Coalescing Credit Controller

This block holds a small bank of interrupt vectors for a network device. Software reaches every vector through one 32-bit register window. Each vector keeps a signed credit count that its own event pulse raises, a mask bit, a mask-on-fire option and a coalescing timer. The timer reloads from a programmable start value and counts down on a shared timebase tick. A vector's interrupt line is high while it has positive credit, is unmasked and its timer has run out.

Software services a vector by writing its credits word. The low half of that word gives the number of events consumed, and the bank subtracts it from the count. Two flag bits in the same word can unmask the vector and restart its timer, so a single store returns credit and re-arms the vector. If mask-on-fire is set, the vector masks itself on the clock edge after its line goes high. The line is then high for exactly one cycle, and the vector stays quiet until software unmasks it.

Each vector occupies eight words. The word address is `{vector, word[2:0]}`, and the vector count is a power of two.

Top module: `intr_coal_ctrl`

## Requirements
- R1: After reset every vector reads start value 0, mask 1, credits 0, mask-on-fire 0 and timer 0, and no interrupt line is high.
- R2: Word 0 holds the coalescing start value. A write stores the written value when it is 63 or less and stores 63 otherwise. A read returns the stored value in bits 5:0, with all other bits 0.
- R3: Word 1 (mask) and word 3 (mask-on-fire) store bit 0 of a write, where 1 means masked or enabled. A read returns that bit in bit 0 and zeros elsewhere.
- R4: Each cycle a vector's event input is high adds one to its credit count. The count saturates at +32767 (0x7FFF).
- R5: A write to word 2 subtracts bits 15:0 of the written value, taken as a signed 16-bit number, from the credit count. An event in the same cycle is also counted. The result saturates at -32768 (0x8000). A read of word 2 returns the count in bits 15:0, with bits 31:16 zero.
- R6: Bit 16 set in a word-2 write clears the vector's mask.
- R7: Bit 17 set in a word-2 write reloads the timer from the stored start value. Setting bits 16 and 17 together both unmasks the vector and restarts its timer.
- R8: On each cycle the tick input is high, every nonzero timer drops by one. A timer at zero stays at zero. With no tick and no restart, a timer holds its value. Word 4 reads the timer in bits 5:0.
- R9: A vector's interrupt line is high exactly when its credit is above zero, its mask is 0 and its timer is zero.
- R10: With mask-on-fire set, a vector whose line is high sets its own mask on the next clock edge. With mask-on-fire clear, the line stays high.
- R11: Words 5 to 7 read as zero and ignore writes. Writes to word 4 are ignored.
- R12: Address bits above bit 2 select the vector. A write changes only the addressed vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | $clog2(NUM_VEC)+3 | Word address: vector in the upper bits, word in bits 2:0 |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| evt_in | input | NUM_VEC | One event per vector per cycle while high |
| tick | input | 1 | Coalescing timebase step |
| irq | output | NUM_VEC | Interrupt line per vector |

## Verification
The assertions check the following on every cycle:
- a masked vector, a running timer or a non-positive credit keeps the line low;
- timers step down only on a tick and otherwise hold;
- start-value clamping, mask writes, the unmask flag, the restart flag and mask-on-fire each take effect on the following edge;
- a saturated count stays saturated;
- the reserved words read zero.

Only the bench scenarios can show the arithmetic values across a sweep:
- the credit sums at both saturation limits;
- an event and a credit return landing in the same cycle;
- the clamp over a range of written values;
- the full path from event to interrupt line;
- the isolation of one vector from writes to another.

// File: rtl/intr_coal_pkg.sv
package intr_coal_pkg;
  localparam int COAL_W  = 6;
  localparam int COAL_MAX = (1 << COAL_W) - 1;
  localparam int CRED_W  = 16;

  typedef enum logic [2:0] {
    W_INIT  = 3'd0,
    W_MASK  = 3'd1,
    W_CRED  = 3'd2,
    W_MOA   = 3'd3,
    W_TIMER = 3'd4
  } word_e;

  function automatic logic [COAL_W-1:0] clamp_init(input logic [31:0] w);
    if (w > 32'(COAL_MAX)) return COAL_W'(COAL_MAX);
    return w[COAL_W-1:0];
  endfunction

  function automatic logic [CRED_W-1:0] cred_next(input logic [CRED_W-1:0] cur,
                                                   input logic add,
                                                   input logic [CRED_W-1:0] sub);
    logic signed [CRED_W+1:0] a, b, c, s;
    a = CRED_W'($signed(cur));
    a = $signed({{2{cur[CRED_W-1]}}, cur});
    b = $signed({{(CRED_W+1){1'b0}}, add});
    c = $signed({{2{sub[CRED_W-1]}}, sub});
    s = a + b - c;
    if (s > $signed((CRED_W+2)'((1 << (CRED_W-1)) - 1)))
      return {1'b0, {(CRED_W-1){1'b1}}};
    if (s < -$signed((CRED_W+2)'(1 << (CRED_W-1))))
      return {1'b1, {(CRED_W-1){1'b0}}};
    return s[CRED_W-1:0];
  endfunction
endpackage

// File: rtl/intr_reg_dec.sv
module intr_reg_dec
  import intr_coal_pkg::*;
#(
  parameter int NUM_VEC = 8,
  localparam int VEC_W  = $clog2(NUM_VEC),
  localparam int ADDR_W = VEC_W + 3
) (
  input  logic                              reg_wr,
  input  logic [ADDR_W-1:0]                 reg_addr,
  input  logic [NUM_VEC-1:0][COAL_W-1:0]    init_i,
  input  logic [NUM_VEC-1:0]                mask_i,
  input  logic [NUM_VEC-1:0]                moa_i,
  input  logic [NUM_VEC-1:0][CRED_W-1:0]    cred_i,
  input  logic [NUM_VEC-1:0][COAL_W-1:0]    timer_i,
  output logic [NUM_VEC-1:0]                wr_init,
  output logic [NUM_VEC-1:0]                wr_mask,
  output logic [NUM_VEC-1:0]                wr_cred,
  output logic [NUM_VEC-1:0]                wr_moa,
  output logic [31:0]                       rdata
);
  logic [VEC_W-1:0] vsel;
  logic [2:0]       wsel;
  assign vsel = reg_addr[ADDR_W-1:3];
  assign wsel = reg_addr[2:0];

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_dec
    logic hit;
    assign hit        = reg_wr && (vsel == VEC_W'(v));
    assign wr_init[v] = hit && (wsel == W_INIT);
    assign wr_mask[v] = hit && (wsel == W_MASK);
    assign wr_cred[v] = hit && (wsel == W_CRED);
    assign wr_moa[v]  = hit && (wsel == W_MOA);
  end

  always_comb begin
    rdata = '0;
    case (wsel)
      W_INIT:  rdata = 32'(init_i[vsel]);
      W_MASK:  rdata = 32'(mask_i[vsel]);
      W_CRED:  rdata = 32'(cred_i[vsel]);
      W_MOA:   rdata = 32'(moa_i[vsel]);
      W_TIMER: rdata = 32'(timer_i[vsel]);
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/intr_vec.sv
module intr_vec
  import intr_coal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_init,
  input  logic              wr_mask,
  input  logic              wr_cred,
  input  logic              wr_moa,
  input  logic [31:0]       wdata,
  input  logic              evt,
  input  logic              tick,
  output logic [COAL_W-1:0] init_o,
  output logic              mask_o,
  output logic              moa_o,
  output logic [CRED_W-1:0] cred_o,
  output logic [COAL_W-1:0] timer_o,
  output logic              irq_o,
  output logic              restart_o,
  output logic              unmask_o
);
  logic [COAL_W-1:0] init_q, timer_q;
  logic              mask_q, moa_q;
  logic [CRED_W-1:0] cred_q, sub;

  assign restart_o = wr_cred && wdata[17];
  assign unmask_o  = wr_cred && wdata[16];
  assign sub       = wr_cred ? wdata[CRED_W-1:0] : '0;
  assign irq_o     = !cred_q[CRED_W-1] && (cred_q != '0) && !mask_q && (timer_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      init_q  <= '0;
      timer_q <= '0;
      mask_q  <= 1'b1;
      moa_q   <= 1'b0;
      cred_q  <= '0;
    end else begin
      if (wr_init) init_q <= clamp_init(wdata);
      if (wr_moa)  moa_q  <= wdata[0];
      if (wr_cred || evt) cred_q <= cred_next(cred_q, evt, sub);
      if (restart_o)                   timer_q <= init_q;
      else if (tick && timer_q != '0)  timer_q <= timer_q - 1'b1;
      if (wr_mask)              mask_q <= wdata[0];
      else if (unmask_o)        mask_q <= 1'b0;
      else if (irq_o && moa_q)  mask_q <= 1'b1;
    end
  end

  assign init_o  = init_q;
  assign mask_o  = mask_q;
  assign moa_o   = moa_q;
  assign cred_o  = cred_q;
  assign timer_o = timer_q;
endmodule

// File: rtl/intr_coal_ctrl.sv
module intr_coal_ctrl
  import intr_coal_pkg::*;
#(
  parameter int NUM_VEC = 8,
  localparam int ADDR_W = $clog2(NUM_VEC) + 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic [NUM_VEC-1:0] evt_in,
  input  logic               tick,
  output logic [NUM_VEC-1:0] irq
);
  logic [NUM_VEC-1:0][COAL_W-1:0] init_w, timer_w;
  logic [NUM_VEC-1:0][CRED_W-1:0] cred_w;
  logic [NUM_VEC-1:0] mask_w, moa_w, restart_w, unmask_w;
  logic [NUM_VEC-1:0] wr_init, wr_mask, wr_cred, wr_moa;

  intr_reg_dec #(.NUM_VEC(NUM_VEC)) dec_i (
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .init_i   (init_w),
    .mask_i   (mask_w),
    .moa_i    (moa_w),
    .cred_i   (cred_w),
    .timer_i  (timer_w),
    .wr_init  (wr_init),
    .wr_mask  (wr_mask),
    .wr_cred  (wr_cred),
    .wr_moa   (wr_moa),
    .rdata    (reg_rdata)
  );

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
    intr_vec vec_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_init   (wr_init[v]),
      .wr_mask   (wr_mask[v]),
      .wr_cred   (wr_cred[v]),
      .wr_moa    (wr_moa[v]),
      .wdata     (reg_wdata),
      .evt       (evt_in[v]),
      .tick      (tick),
      .init_o    (init_w[v]),
      .mask_o    (mask_w[v]),
      .moa_o     (moa_w[v]),
      .cred_o    (cred_w[v]),
      .timer_o   (timer_w[v]),
      .irq_o     (irq[v]),
      .restart_o (restart_w[v]),
      .unmask_o  (unmask_w[v])
    );
  end
endmodule

// File: rtl/intr_coal_chk.sv
module intr_coal_chk
  import intr_coal_pkg::*;
#(
  parameter int NUM_VEC = 8,
  localparam int ADDR_W = $clog2(NUM_VEC) + 3
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic [ADDR_W-1:0]              reg_addr,
  input logic [31:0]                    reg_wdata,
  input logic [31:0]                    reg_rdata,
  input logic                           tick,
  input logic [NUM_VEC-1:0]             irq,
  input logic [NUM_VEC-1:0][COAL_W-1:0] init_w,
  input logic [NUM_VEC-1:0][COAL_W-1:0] timer_w,
  input logic [NUM_VEC-1:0][CRED_W-1:0] cred_w,
  input logic [NUM_VEC-1:0]             mask_w,
  input logic [NUM_VEC-1:0]             moa_w,
  input logic [NUM_VEC-1:0]             restart_w,
  input logic [NUM_VEC-1:0]             unmask_w,
  input logic [NUM_VEC-1:0]             wr_init,
  input logic [NUM_VEC-1:0]             wr_mask,
  input logic [NUM_VEC-1:0]             wr_cred,
  input logic [NUM_VEC-1:0]             wr_moa
);
  // R11
  rsvd_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr[2:0] > 3'd4) |-> (reg_rdata == 32'd0));

  // R12
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_init, wr_mask, wr_cred, wr_moa}));

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_chk
    // R2
    init_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_init[v] |=> (init_w[v] == ((|$past(reg_wdata[31:6])) ? 6'h3f : $past(reg_wdata[5:0]))));
    // R3
    mask_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_mask[v] |=> (mask_w[v] == $past(reg_wdata[0])));
    // R3
    moa_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_moa[v] |=> (moa_w[v] == $past(reg_wdata[0])));
    // R6
    unmask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      unmask_w[v] |=> !mask_w[v]);
    // R7
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restart_w[v] |=> (timer_w[v] == $past(init_w[v])));
    // R8
    timer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !restart_w[v]) |=> $stable(timer_w[v]));
    // R8
    timer_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !restart_w[v] && timer_w[v] != '0) |=> (timer_w[v] == $past(timer_w[v]) - 6'd1));
    // R9
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mask_w[v] |-> !irq[v]);
    // R9
    irq_timer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (timer_w[v] != '0) |-> !irq[v]);
    // R9
    irq_cred_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cred_w[v][CRED_W-1] || cred_w[v] == '0) |-> !irq[v]);
    // R10
    moa_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq[v] && moa_w[v] && !wr_mask[v] && !unmask_w[v]) |=> mask_w[v]);
    // R4
    cred_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cred_w[v] == 16'h7fff && !wr_cred[v]) |=> (cred_w[v] == 16'h7fff));
  end
endmodule

bind intr_coal_ctrl intr_coal_chk #(.NUM_VEC(NUM_VEC)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .tick      (tick),
  .irq       (irq),
  .init_w    (init_w),
  .timer_w   (timer_w),
  .cred_w    (cred_w),
  .mask_w    (mask_w),
  .moa_w     (moa_w),
  .restart_w (restart_w),
  .unmask_w  (unmask_w),
  .wr_init   (wr_init),
  .wr_mask   (wr_mask),
  .wr_cred   (wr_cred),
  .wr_moa    (wr_moa)
);

// File: tb/intr_coal_ctrl_tb_top.sv
module intr_coal_ctrl_tb_top;
  localparam int NV = 8;
  localparam int AW = $clog2(NV) + 3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [NV-1:0] evt_in = '0;
  logic          tick = 1'b0;
  logic [NV-1:0] irq;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  intr_coal_ctrl #(.NUM_VEC(NV)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_in(evt_in),
    .tick(tick), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int v, input int w, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = AW'(v * 8 + w); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic chkrd(input string req, input int v, input int w, input logic [31:0] exp);
    @(negedge clk);
    reg_addr = AW'(v * 8 + w);
    #1;
    chk(req, reg_rdata, exp);
  endtask

  task automatic evt(input int v, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); evt_in[v] = 1'b1;
      @(negedge clk); evt_in[v] = 1'b0;
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic chk_irq_now(input string req, input logic [31:0] exp);
    #1;
    chk(req, 32'(irq), exp);
  endtask

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values on every vector
    for (int v = 0; v < NV; v++) begin
      chkrd("R1 init", v, 0, 0);
      chkrd("R1 mask", v, 1, 1);
      chkrd("R1 cred", v, 2, 0);
      chkrd("R1 moa", v, 3, 0);
      chkrd("R1 timer", v, 4, 0);
    end
    chk_irq_now("R1 irq", 0);

    // R2 clamp sweep on vector 0
    for (int val = 0; val <= 70; val++) begin
      wr(0, 0, 32'(val));
      chkrd("R2 clamp", 0, 0, 32'(val > 63 ? 63 : val));
    end
    wr(0, 0, 32'hFFFF_FFFF);
    chkrd("R2 clamp max", 0, 0, 63);
    // R12 per-vector start values
    for (int v = 0; v < NV; v++) wr(v, 0, 32'(v * 7 + 1));
    for (int v = 0; v < NV; v++) chkrd("R12 init isolation", v, 0, 32'(v * 7 + 1));

    // R3 mask and mask-on-fire bit 0
    for (int v = 0; v < NV; v++) begin
      wr(v, 1, 32'hFFFF_FFFE); chkrd("R3 mask clr", v, 1, 0);
      wr(v, 1, 32'h0000_0001); chkrd("R3 mask set", v, 1, 1);
      wr(v, 3, 32'h8000_0001); chkrd("R3 moa set", v, 3, 1);
      wr(v, 3, 32'h0000_0000); chkrd("R3 moa clr", v, 3, 0);
    end

    // R4 / R5 credit arithmetic on vector 2
    evt(2, 5);                 chkrd("R4 events", 2, 2, 5);
    wr(2, 2, 32'd3);           chkrd("R5 sub 3", 2, 2, 2);
    wr(2, 2, 32'h0000_FFFF);   chkrd("R5 sub -1", 2, 2, 3);
    wr(2, 2, 32'h0000_8000);   chkrd("R5 high sat", 2, 2, 32'h7FFF);
    evt(2, 1);                 chkrd("R4 sat", 2, 2, 32'h7FFF);
    wr(2, 2, 32'h0000_7FFF);   chkrd("R5 to zero", 2, 2, 0);
    wr(2, 2, 32'h0000_7FFF);   chkrd("R5 negative", 2, 2, 32'h8001);
    wr(2, 2, 32'd2);           chkrd("R5 low sat", 2, 2, 32'h8000);
    wr(2, 2, 32'h0000_8000);   chkrd("R5 back zero", 2, 2, 0);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = AW'(2 * 8 + 2); reg_wdata = 32'd4; evt_in[2] = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; evt_in[2] = 1'b0;
    chkrd("R5 same-cycle event", 2, 2, 32'hFFFD);
    chkrd("R5 no unmask", 2, 1, 1);
    for (int v = 0; v < NV; v++) if (v != 2) chkrd("R12 cred isolation", v, 2, 0);
    wr(2, 2, 32'h0000_FFFD);   chkrd("R5 restore", 2, 2, 0);

    // R7 / R8 timer on vector 1, start value 8
    wr(1, 2, 32'h0002_0000);
    chkrd("R7 restart", 1, 4, 8);
    chkrd("R7 mask kept", 1, 1, 1);
    for (int k = 1; k <= 8; k++) begin
      ticks(1);
      chkrd("R8 step", 1, 4, 32'(8 - k));
    end
    ticks(1);                  chkrd("R8 floor", 1, 4, 0);
    wr(1, 2, 32'h0002_0000);
    repeat (3) @(negedge clk);
    chkrd("R8 hold", 1, 4, 8);
    ticks(8);                  chkrd("R8 drained", 1, 4, 0);

    // R9 firing condition on vector 1
    wr(1, 0, 32'd3);
    evt(1, 2);
    wr(1, 2, 32'h0003_0000);
    chk_irq_now("R9 timer running", 0);
    chkrd("R7 rearm mask", 1, 1, 0);
    chkrd("R7 rearm timer", 1, 4, 3);
    ticks(2);                  chk_irq_now("R9 timer 1", 0);
    ticks(1);                  chk_irq_now("R9 fire", 32'h02);
    wr(1, 2, 32'd2);           chk_irq_now("R9 no credit", 0);
    wr(1, 1, 32'd1);
    evt(1, 1);                 chk_irq_now("R9 masked", 0);
    wr(1, 2, 32'h0001_0000);   chk_irq_now("R6 unmask fire", 32'h02);
    chkrd("R6 mask read", 1, 1, 0);
    wr(1, 2, 32'd1);           chk_irq_now("R9 drained", 0);
    wr(1, 1, 32'd1);

    // R10 mask-on-fire on vector 3, plain on vector 4
    wr(3, 3, 32'd1);
    wr(3, 0, 32'd0);
    evt(3, 1);
    wr(3, 2, 32'h0001_0000);   chk_irq_now("R10 one pulse", 32'h08);
    chkrd("R10 auto mask", 3, 1, 1);
    chk_irq_now("R10 line down", 0);
    chkrd("R10 credit kept", 3, 2, 1);
    wr(4, 0, 32'd0);
    evt(4, 1);
    wr(4, 2, 32'h0001_0000);
    repeat (3) @(negedge clk);
    chk_irq_now("R10 no auto mask", 32'h10);
    chkrd("R10 mask stays 0", 4, 1, 0);
    wr(4, 2, 32'd1);
    wr(4, 1, 32'd1);

    // R11 reserved and read-only words
    for (int w = 5; w < 8; w++) begin
      wr(0, w, 32'hFFFF_FFFF);
      chkrd("R11 reserved", 0, w, 0);
    end
    wr(0, 4, 32'h0000_003F);
    chkrd("R11 timer ro", 0, 4, 0);
    chkrd("R11 init kept", 0, 0, 1);
    chkrd("R11 mask kept", 0, 1, 1);
    chkrd("R11 cred kept", 0, 2, 0);
    chkrd("R11 moa kept", 0, 3, 0);

    done = 1;
    summary();
    $finish;
  end
endmodule